// File: doc/BRIEF.md
# Interrupt Distributor

This block collects interrupt requests and forwards them to a small set of processors. Its register port is 32 bits wide, word addressed, and every access carries the identity of the processor that makes it. Each interrupt has the following state:

- an enable bit,
- a pending bit,
- an active bit,
- a trigger type,
- a priority byte,
- a target byte.

For each processor, the block shows the most urgent eligible interrupt on that processor's request outputs. That processor takes the interrupt with an acknowledge pulse. It retires the interrupt with an end-of-interrupt pulse that carries the ID.

IDs 0 to 31 are private to each processor. Their enable, pending and active state is kept per processor, so the same address shows a different copy to each processor. IDs 0 to 15 have no input lines. Software raises them by writing a target list and an ID to a single register. IDs 16 to 31 come from per-processor local lines. IDs 32 and up come from shared lines, and their target byte routes them to processors.

The register map is in word addresses:

| Address | Register |
|---|---|
| 0x000 | Control |
| 0x001 | Type |
| 0x040+k | Enable set |
| 0x060+k | Enable clear |
| 0x100+w | Priority |
| 0x200+w | Target |
| 0x300+w | Trigger configuration |
| 0x3C0 | Software interrupt |

Top module: `irq_distributor`

## Requirements
- R1: After reset, control, all enables, pending, active, priority, target and configuration state are zero, and no processor sees a request.
- R2: Writing 1s to enable-set word k (0x040+k) enables IDs 32k+bit. Writing 1s to enable-clear word k (0x060+k) disables them. Zero bits change nothing. Reading either address returns the current enable word.
- R3: Enable word 0 (IDs 0 to 31) is held separately for each processor. A write by one processor is invisible to the other.
- R4: Configuration word w (0x300+w) holds 2 bits per ID, with ID 16w+j at bits 2j+1:2j. Bit 2j+1 set means edge-triggered and clear means level-sensitive. Bit 2j reads 0. IDs 0 to 15 always read as edge (word 0 reads 0xAAAAAAAA) and ignore writes.
- R5: Priority word w (0x100+w) holds the byte of ID 4w+b at bits 8b+7:8b. It reads back as written.
- R6: Target word w (0x200+w) holds a byte per ID in the same layout. Bit n routes the ID to processor n. For IDs 0 to 31 the byte reads as the bit of the reading processor only, and writes are ignored.
- R7: Bit 0 of control (0x000) enables forwarding. While it is 0, no processor sees a request.
- R8: The type register (0x001) reads NUM_IRQ/32-1 in bits 4:0 and 0 elsewhere.
- R9: A write to 0x3C0 sets ID wdata[3:0] pending in the private copy of each processor n whose bit 16+n is set. Processors whose bit is clear are not affected.
- R10: An edge-configured line sets pending on a 0-to-1 transition, and pending stays set until it is acknowledged. A level-configured line is pending exactly while it is high, one cycle after the line changes.
- R11: Each processor sees, among interrupts that are enabled, pending, not active and routed to it, the one with the lowest priority value. Ties go to the lowest ID. irq_id and irq_prio carry that interrupt's ID and priority.
- R12: An acknowledge marks the shown ID active and clears its edge pending state. An active ID is not shown again until end-of-interrupt names it. For IDs 0 to 31 the end-of-interrupt must come from the same processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (10) | Word address |
| reg_wdata | input | 32 | Write data |
| reg_cpu | input | CW (1) | Identity of the accessing processor |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| shared_irq | input | NUM_IRQ-32 (32) | Lines of IDs 32 and up |
| local_irq | input | NUM_CPU*16 (32) | Per-processor lines of IDs 16 to 31; processor c, ID i at bit 16c+i-16 |
| ack | input | NUM_CPU (2) | Acknowledge of the shown interrupt, per processor |
| eoi | input | NUM_CPU (2) | End-of-interrupt strobe, per processor |
| eoi_id | input | NUM_CPU*IW (12) | ID retired by each processor |
| irq_req | output | NUM_CPU (2) | Request present, per processor |
| irq_id | output | NUM_CPU*IW (12) | ID shown to each processor |
| irq_prio | output | NUM_CPU*8 (16) | Priority shown to each processor |

## Verification
The bench checks the following corner cases:

- **Fixed configuration of the software IDs.** A write to those bits that took effect would turn them level-sensitive.
- **Per-processor copy of enable word 0.** A shared copy would leak one processor's enables to the other.
- **Tie on priority.** Picking the highest ID instead of the lowest would show the wrong interrupt.
- **Level line held high across acknowledge.** The interrupt must reappear only after end-of-interrupt; a design that drops the active bit would show it at once.
- **One-cycle edge pulse.** The pulse must stay pending until acknowledged; a design that samples the level would lose it.
- **Software interrupt aimed at one processor.** The other processor must stay quiet.

Random mixes of priorities, enable set and clear masks and line levels are then compared against a model of the selection rule.

// File: rtl/irq_distributor.sv
module irq_distributor #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int AW = 10,
  localparam int CW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int IW = $clog2(NUM_IRQ)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [AW-1:0]          reg_addr,
  input  logic [31:0]            reg_wdata,
  input  logic [CW-1:0]          reg_cpu,
  output logic [31:0]            reg_rdata,
  input  logic [NUM_IRQ-33:0]    shared_irq,
  input  logic [NUM_CPU*16-1:0]  local_irq,
  input  logic [NUM_CPU-1:0]     ack,
  input  logic [NUM_CPU-1:0]     eoi,
  input  logic [NUM_CPU*IW-1:0]  eoi_id,
  output logic [NUM_CPU-1:0]     irq_req,
  output logic [NUM_CPU*IW-1:0]  irq_id,
  output logic [NUM_CPU*8-1:0]   irq_prio
);
  localparam int NW = NUM_IRQ / 32;
  localparam int GLB = NUM_IRQ - 32;
  localparam int A_CTRL = 'h000, A_TYPE = 'h001, A_ENS = 'h040, A_ENC = 'h060;
  localparam int A_PRI = 'h100, A_TGT = 'h200, A_CFG = 'h300, A_SWI = 'h3C0;

  logic                          en_dist;
  logic [NUM_CPU-1:0][31:0]      en_loc, pd_loc, ac_loc, ack_loc, eoi_loc;
  logic [GLB-1:0]                en_glb, pd_glb, ac_glb, ack_glb, eoi_glb, glb_prev;
  logic [NUM_CPU*16-1:0]         loc_prev;
  logic [NUM_IRQ-1:0][7:0]       prio;
  logic [GLB-1:0][7:0]           tgt;
  logic [NUM_IRQ-1:16]           cfg_edge;
  logic [NUM_CPU-1:0][GLB-1:0]   tgt_bit;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] cand;
  logic [NUM_CPU-1:0]            sel_ok;
  logic [NUM_CPU-1:0][IW-1:0]    sel_id;
  logic [NUM_CPU-1:0][7:0]       sel_pr;
  logic [31:0]                   rd;
  logic                          we_swi;

  assign we_swi = reg_we && reg_addr == AW'(A_SWI);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar j = 0; j < GLB; j++) begin : g_tb
      assign tgt_bit[c][j] = tgt[j][c];
    end
    assign cand[c] = {en_glb & pd_glb & ~ac_glb & tgt_bit[c],
                      en_loc[c] & pd_loc[c] & ~ac_loc[c]} & {NUM_IRQ{en_dist}};
    assign irq_req[c]           = sel_ok[c];
    assign irq_id[c*IW +: IW]   = sel_id[c];
    assign irq_prio[c*8 +: 8]   = sel_pr[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_dist <= 1'b0; en_loc <= '0; en_glb <= '0;
      prio <= '0; tgt <= '0; cfg_edge <= '0;
    end else if (reg_we) begin
      if (reg_addr == AW'(A_CTRL)) en_dist <= reg_wdata[0];
      if (reg_addr == AW'(A_ENS)) en_loc[reg_cpu] <= en_loc[reg_cpu] | reg_wdata;
      if (reg_addr == AW'(A_ENC)) en_loc[reg_cpu] <= en_loc[reg_cpu] & ~reg_wdata;
      for (int k = 1; k < NW; k++) begin
        if (reg_addr == AW'(A_ENS + k))
          en_glb[(k-1)*32 +: 32] <= en_glb[(k-1)*32 +: 32] | reg_wdata;
        if (reg_addr == AW'(A_ENC + k))
          en_glb[(k-1)*32 +: 32] <= en_glb[(k-1)*32 +: 32] & ~reg_wdata;
      end
      for (int i = 0; i < NUM_IRQ; i++)
        if (reg_addr == AW'(A_PRI + i/4)) prio[i] <= reg_wdata[8*(i%4) +: 8];
      for (int i = 32; i < NUM_IRQ; i++)
        if (reg_addr == AW'(A_TGT + i/4)) tgt[i-32] <= reg_wdata[8*(i%4) +: 8];
      for (int i = 16; i < NUM_IRQ; i++)
        if (reg_addr == AW'(A_CFG + i/16)) cfg_edge[i] <= reg_wdata[2*(i%16)+1];
    end
  end

  always_comb begin
    ack_glb = '0; eoi_glb = '0; ack_loc = '0; eoi_loc = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      sel_ok[c] = 1'b0; sel_id[c] = '0; sel_pr[c] = '1;
      for (int i = 0; i < NUM_IRQ; i++)
        if (cand[c][i] && (!sel_ok[c] || prio[i] < sel_pr[c])) begin
          sel_ok[c] = 1'b1; sel_pr[c] = prio[i]; sel_id[c] = IW'(i);
        end
      for (int i = 0; i < 32; i++) begin
        ack_loc[c][i] = ack[c] && sel_ok[c] && sel_id[c] == IW'(i);
        eoi_loc[c][i] = eoi[c] && eoi_id[c*IW +: IW] == IW'(i);
      end
      for (int j = 0; j < GLB; j++) begin
        ack_glb[j] = ack_glb[j] | (ack[c] && sel_ok[c] && sel_id[c] == IW'(j+32));
        eoi_glb[j] = eoi_glb[j] | (eoi[c] && eoi_id[c*IW +: IW] == IW'(j+32));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd_glb <= '0; ac_glb <= '0; glb_prev <= '0;
      pd_loc <= '0; ac_loc <= '0; loc_prev <= '0;
    end else begin
      glb_prev <= shared_irq;
      loc_prev <= local_irq;
      ac_glb   <= (ac_glb & ~eoi_glb) | ack_glb;
      for (int j = 0; j < GLB; j++)
        pd_glb[j] <= cfg_edge[j+32]
                     ? ((pd_glb[j] & ~ack_glb[j]) | (shared_irq[j] & ~glb_prev[j]))
                     : shared_irq[j];
      for (int c = 0; c < NUM_CPU; c++) begin
        ac_loc[c] <= (ac_loc[c] & ~eoi_loc[c]) | ack_loc[c];
        for (int i = 0; i < 16; i++)
          pd_loc[c][i] <= (pd_loc[c][i] & ~ack_loc[c][i]) |
                          (we_swi && reg_wdata[16+c] && reg_wdata[3:0] == 4'(i));
        for (int i = 16; i < 32; i++)
          pd_loc[c][i] <= cfg_edge[i]
                          ? ((pd_loc[c][i] & ~ack_loc[c][i]) |
                             (local_irq[c*16+i-16] & ~loc_prev[c*16+i-16]))
                          : local_irq[c*16+i-16];
      end
    end
  end

  always_comb begin
    rd = '0;
    if (reg_addr == AW'(A_CTRL)) rd[0] = en_dist;
    if (reg_addr == AW'(A_TYPE)) rd[4:0] = 5'(NW - 1);
    if (reg_addr == AW'(A_ENS) || reg_addr == AW'(A_ENC)) rd = en_loc[reg_cpu];
    for (int k = 1; k < NW; k++)
      if (reg_addr == AW'(A_ENS + k) || reg_addr == AW'(A_ENC + k))
        rd = en_glb[(k-1)*32 +: 32];
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (reg_addr == AW'(A_PRI + i/4)) rd[8*(i%4) +: 8] = prio[i];
      if (reg_addr == AW'(A_TGT + i/4))
        rd[8*(i%4) +: 8] = (i < 32) ? (8'd1 << reg_cpu) : tgt[(i < 32) ? 0 : i-32];
      if (reg_addr == AW'(A_CFG + i/16))
        rd[2*(i%16)+1] = (i < 16) ? 1'b1 : cfg_edge[(i < 16) ? 16 : i];
    end
  end
  assign reg_rdata = rd;
endmodule

// File: rtl/irq_distributor_chk.sv
module irq_distributor_chk #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int AW = 10,
  localparam int IW = $clog2(NUM_IRQ)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [AW-1:0]         reg_addr,
  input logic [31:0]           reg_wdata,
  input logic [31:0]           reg_rdata,
  input logic                  en_dist,
  input logic [NUM_IRQ-33:0]   en_glb,
  input logic [NUM_CPU-1:0]    ack,
  input logic [NUM_CPU-1:0]    irq_req,
  input logic [NUM_CPU*IW-1:0] irq_id
);
  localparam int NW = NUM_IRQ / 32;

  // R7
  fwd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_dist |-> irq_req == '0);

  // R8
  type_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == AW'('h001) |-> reg_rdata == 32'(NW - 1));

  // R4
  swi_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == AW'('h300) |-> reg_rdata == 32'hAAAA_AAAA);

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == AW'('h041) |=> (en_glb[31:0] & $past(reg_wdata)) == $past(reg_wdata));

  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == AW'('h061) |=> (en_glb[31:0] & $past(reg_wdata)) == 32'd0);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_ack
    // R12
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack[c] && irq_req[c] |=>
        !(irq_req[c] && irq_id[c*IW +: IW] == $past(irq_id[c*IW +: IW])));
  end
endmodule

bind irq_distributor irq_distributor_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .en_dist(en_dist), .en_glb(en_glb[31:0]), .ack(ack),
  .irq_req(irq_req), .irq_id(irq_id));

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
  localparam int NI = 64, NC = 2, IW = 6;

  logic            clk = 0, rst_n = 0, reg_we = 0;
  logic [9:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0, reg_rdata;
  logic [0:0]      reg_cpu = '0;
  logic [31:0]     shared_irq = '0;
  logic [31:0]     local_irq = '0;
  logic [NC-1:0]   ack = '0, eoi = '0, irq_req;
  logic [NC*IW-1:0] eoi_id = '0, irq_id;
  logic [NC*8-1:0] irq_prio;

  int checks = 0, fails = 0;
  logic [31:0] d;
  logic [7:0]  m_pr [32];
  bit          m_en [32];

  always #10 clk = ~clk;

  irq_distributor dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_cpu(reg_cpu), .reg_rdata(reg_rdata), .shared_irq(shared_irq), .local_irq(local_irq),
    .ack(ack), .eoi(eoi), .eoi_id(eoi_id), .irq_req(irq_req), .irq_id(irq_id),
    .irq_prio(irq_prio));

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] v, int c = 0);
    @(negedge clk);
    reg_we = 1; reg_addr = 10'(a); reg_wdata = v; reg_cpu = 1'(c);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(int a, int c, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 10'(a); reg_cpu = 1'(c);
    #1 v = reg_rdata;
  endtask

  task automatic do_ack(int c);
    @(negedge clk); ack[c] = 1;
    @(negedge clk); ack = '0;
  endtask

  task automatic do_eoi(int c, int id);
    @(negedge clk); eoi[c] = 1; eoi_id[c*IW +: IW] = IW'(id);
    @(negedge clk); eoi = '0;
  endtask

  task automatic lines(logic [31:0] v);
    @(negedge clk); shared_irq = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] req_of(int c);
    return irq_req[c] ? {24'd1, 2'b0, irq_id[c*IW +: IW]} : 32'd0;
  endfunction

  function automatic logic [31:0] exp_of(int id);
    return {24'd1, 2'b0, 6'(id)};
  endfunction

  function automatic logic [31:0] model(logic [31:0] ln);
    int best = 256, bid = -1;
    for (int i = 0; i < 32; i++)
      if (m_en[i] && ln[i] && int'(m_pr[i]) < best) begin best = int'(m_pr[i]); bid = i; end
    return (bid < 0) ? 32'd0 : exp_of(bid + 32);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 no request", 32'(irq_req), 0);
    rd('h000, 0, d); chk("R1 control", d, 0);
    rd('h041, 0, d); chk("R1 enable", d, 0);
    rd('h040, 1, d); chk("R1 private enable", d, 0);
    // R8 type
    rd('h001, 0, d); chk("R8 type", d, 32'd1);
    // R4 configuration
    rd('h300, 0, d); chk("R4 fixed cfg", d, 32'hAAAAAAAA);
    wr('h300, 0); rd('h300, 0, d); chk("R4 fixed cfg write ignored", d, 32'hAAAAAAAA);
    wr('h302, '1); rd('h302, 0, d); chk("R4 low bits read 0", d, 32'hAAAAAAAA);
    wr('h302, 0); rd('h302, 0, d); chk("R4 level", d, 0);
    // R2 set/clear
    wr('h041, 32'h5); rd('h041, 0, d); chk("R2 set", d, 32'h5);
    rd('h061, 0, d); chk("R2 read clear addr", d, 32'h5);
    wr('h061, 32'h1); rd('h041, 0, d); chk("R2 clear", d, 32'h4);
    wr('h061, 32'h4); rd('h041, 0, d); chk("R2 clear all", d, 0);
    // R3 banked
    wr('h040, 32'h8, 0); rd('h040, 0, d); chk("R3 own copy", d, 32'h8);
    rd('h040, 1, d); chk("R3 other copy", d, 0);
    // R5 priority
    wr('h108, 32'h44332211); rd('h108, 0, d); chk("R5 prio word", d, 32'h44332211);
    rd('h109, 0, d); chk("R5 neighbour word", d, 0);
    // R6 target
    wr('h208, 32'h02010201); rd('h208, 0, d); chk("R6 target", d, 32'h02010201);
    wr('h200, '1, 1); rd('h200, 1, d); chk("R6 private target cpu1", d, 32'h02020202);
    rd('h200, 0, d); chk("R6 private target cpu0", d, 32'h01010101);
    // R7 forwarding gate
    wr('h041, 32'h1); lines(32'h1);
    chk("R7 gate off", 32'(irq_req), 0);
    wr('h000, 1);
    chk("R7 gate on", req_of(0), exp_of(32));
    chk("R11 routed only to cpu0", req_of(1), 0);
    // R12 active holds off level line
    do_ack(0); chk("R12 active hidden", req_of(0), 0);
    do_eoi(0, 32); chk("R12 shown after eoi", req_of(0), exp_of(32));
    lines(0); chk("R10 level drops", req_of(0), 0);
    // R10 edge
    wr('h302, 32'h8); wr('h041, 32'h2);
    @(negedge clk) shared_irq = 32'h2;
    @(negedge clk) shared_irq = 0;
    @(negedge clk);
    chk("R10 edge latched", req_of(1), exp_of(33));
    do_ack(1); chk("R10 ack hides edge", req_of(1), 0);
    do_eoi(1, 33); chk("R10 edge pending cleared", req_of(1), 0);
    // R11 priority and ties
    wr('h041, 32'h4); lines(32'h5);
    chk("R11 lower value wins", req_of(0), exp_of(32));
    chk("R11 prio out", 32'(irq_prio[7:0]), 32'h11);
    wr('h108, 32'h44332233); chk("R11 tie lowest id", req_of(0), exp_of(32));
    wr('h108, 32'h44102233); chk("R11 lower value id34", req_of(0), exp_of(34));
    lines(0);
    // R9 software interrupts
    wr('h040, 32'h8, 1);
    wr('h3C0, (32'h1 << 17) | 32'h3);
    chk("R9 targeted cpu1", req_of(1), exp_of(3));
    chk("R9 untargeted cpu0", req_of(0), 0);
    do_ack(1); chk("R12 swi ack", req_of(1), 0);
    do_eoi(1, 3); chk("R9 swi retired", req_of(1), 0);
    wr('h3C0, (32'h3 << 16) | 32'h3);
    chk("R9 both cpu0", req_of(0), exp_of(3));
    chk("R9 both cpu1", req_of(1), exp_of(3));
    do_ack(0); do_ack(1); do_eoi(0, 3); do_eoi(1, 3);
    // random phase R11
    wr('h060, '1, 0); wr('h060, '1, 1); wr('h061, '1);
    wr('h302, 0); wr('h303, 0);
    for (int w = 8; w < 16; w++) wr(w + 'h200, 32'h01010101);
    for (int w = 8; w < 16; w++) wr(w + 'h100, 0);
    for (int i = 0; i < 32; i++) begin m_pr[i] = 0; m_en[i] = 0; end
    void'($urandom(32'd1234));
    for (int it = 0; it < 300; it++) begin
      int w = 8 + int'($urandom_range(7));
      logic [31:0] pv = $urandom;
      logic [31:0] mk = $urandom;
      logic [31:0] ln = $urandom;
      bit st = $urandom_range(1) == 1;
      if (it % 3 == 0) pv = pv & 32'h0303_0303;
      wr('h100 + w, pv);
      for (int b = 0; b < 4; b++) m_pr[(w-8)*4 + b] = pv[8*b +: 8];
      wr(st ? 'h041 : 'h061, mk);
      for (int i = 0; i < 32; i++) if (mk[i]) m_en[i] = st;
      lines(ln);
      chk("R11 random cpu0", req_of(0), model(ln));
      chk("R11 random cpu1", req_of(1), 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule